// File: doc/BRIEF.md
# Serial Index/Data Write Receiver

This block is the write-only serial front end of a display controller. A host shifts 8-bit words over a data line with a serial clock. Each word goes most significant bit first, one bit on each rising serial-clock edge. When a word is complete, the receiver presents it as a parallel byte with a one-cycle valid strobe. The level of a register-select line, taken at the eighth edge of the word, tags the byte. It is either an index, meaning a register address, or display/command data.

The receiver listens only under three conditions together: the interface-mode pair selects serial mode, the low-true chip select is low, and the high-true chip select is high. Dropping either chip select, or leaving serial mode, empties the shift register and the bit counter, so a half-sent word is discarded. A display-initialization input, active low, restarts the bit count. Nothing is ever driven back to the host.

All serial-side inputs are brought into the system clock domain through two-flop synchronizers. Serial-clock rising edges are detected there, and all outputs are registered on the system clock.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, `word_o` is 0, `is_index_o` is 0 and `word_valid_o` is low.
- R2: Bits are taken on rising `sclk` edges, most significant first, so the first bit of a word lands in `word_o[7]` and the eighth in `word_o[0]`.
- R3: Every eighth rising `sclk` edge of a word yields exactly one `word_valid_o` pulse, one system clock long.
- R4: `rsel` is used only at the eighth edge: `rsel`=1 gives `is_index_o`=0 (data/command), `rsel`=0 gives `is_index_o`=1 (index). Its level at the other edges has no effect.
- R5: The bit counter wraps after the eighth edge, so the ninth edge starts the next word's first bit, and consecutive words need no gap.
- R6: Words are received only when `mode_sel` equals 2'b00. With any other value no pulse is produced.
- R7: Words are received only when `sel_n` is 0 and `sel_p` is 1 together. If either is inactive, no pulse is produced.
- R8: Deselection clears the shift register and the bit counter. A partial word is dropped without a pulse, and the next word after reselection is aligned from its first bit.
- R9: While `disp_init_n` is low, the bit counter is held at zero. A partial word is dropped, and counting restarts at the first bit after release.
- R10: `word_o` and `is_index_o` keep the last received word until the next `word_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Interface-mode pair; 2'b00 selects serial |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdata | input | 1 | Serial data from the host |
| rsel | input | 1 | Register select: 1 data/command, 0 index |
| disp_init_n | input | 1 | Display initialization, active low; restarts the bit count |
| word_o | output | 8 | Last received word |
| is_index_o | output | 1 | 1 when the last word is an index |
| word_valid_o | output | 1 | One-cycle strobe when a word completes |

## Verification
The bench goes after word alignment. It cuts words short by deselecting and by pulsing initialization, then sends a full word. A design that kept the stale count would deliver that word early and shifted. It changes the register-select level on all edges but the last, which catches a design that latches the level at the first edge. It sends words back to back to expose a counter that fails to wrap or emits a double pulse. It tries each inactive mode and select combination and checks that the held output word is left alone, so a design that ignored one of the three gating terms would show a stray pulse or a changed byte.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef logic [1:0] if_mode_t;
  localparam if_mode_t MODE_SERIAL = 2'b00;

  // next value of the bit counter, wrapping after the last bit of a word
  function automatic int unsigned bump_count(int unsigned cur, int unsigned bits);
    return (cur + 1 == bits) ? 0 : cur + 1;
  endfunction

  // true when the current edge carries the final bit of a word
  function automatic logic last_bit(int unsigned cur, int unsigned bits);
    return (cur + 1 == bits);
  endfunction

  // register-select low marks an index, high marks data/command
  function automatic logic index_flag(logic rsel_level);
    return ~rsel_level;
  endfunction

  // the block listens only in serial mode with both selects asserted
  function automatic logic link_active(if_mode_t mode, logic cs_low, logic cs_high);
    return (mode == MODE_SERIAL) && !cs_low && cs_high;
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic safe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RESET_VAL[g];
        safe_q <= RESET_VAL[g];
      end else begin
        meta_q <= async_i[g];
        safe_q <= meta_q;
      end
    end
    assign sync_o[g] = safe_q;
  end

endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  // R3 support: a rise can never be reported on two adjacent cycles
  a_r3_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_i,
  input  logic                 init_i,
  input  logic                 rise_i,
  input  logic                 bit_i,
  output logic                 fire_o,
  output logic [WORD_BITS-1:0] word_o
);

  localparam int unsigned CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] sh_q;
  logic                 take_bit;

  assign take_bit = active_i & ~init_i & rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (init_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= {sh_q[WORD_BITS-2:0], bit_i};
      cnt_q <= CNT_W'(bump_count(int'(cnt_q), WORD_BITS));
    end
  end

  assign fire_o = take_bit & last_bit(int'(cnt_q), WORD_BITS);
  assign word_o = {sh_q[WORD_BITS-2:0], bit_i};

  // R8: leaving the active state empties the shifter and its count
  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0) && (sh_q == '0));

  // R9: initialization pins the count at zero
  a_r9_init_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && init_i) |=> (cnt_q == '0));

  // R5: a finished word leaves the counter at the first bit of the next
  a_r5_wrap_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 sel_n,
  input  logic                 sel_p,
  input  logic                 sclk,
  input  logic                 sdata,
  input  logic                 rsel,
  input  logic                 disp_init_n,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 is_index_o,
  output logic                 word_valid_o
);

  localparam int unsigned SYNC_W = 8;
  // bit order: init_n, mode[1:0], sel_p, sel_n, rsel, sdata, sclk
  localparam logic [SYNC_W-1:0] SYNC_RST = 8'b1000_1000;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn;
  logic              sclk_s, sdata_s, rsel_s, sel_n_s, sel_p_s, init_n_s;
  if_mode_t          mode_s;
  logic              active, sclk_rise, fire;
  logic [WORD_BITS-1:0] word_next;

  assign raw_in = {disp_init_n, mode_sel, sel_p, sel_n, rsel, sdata, sclk};

  sync_bank #(.WIDTH(SYNC_W), .RESET_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (syn)
  );

  assign sclk_s   = syn[0];
  assign sdata_s  = syn[1];
  assign rsel_s   = syn[2];
  assign sel_n_s  = syn[3];
  assign sel_p_s  = syn[4];
  assign mode_s   = syn[6:5];
  assign init_n_s = syn[7];

  assign active = link_active(mode_s, sel_n_s, sel_p_s);

  rise_detect u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sclk_s),
    .rise_o  (sclk_rise)
  );

  word_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .init_i   (~init_n_s),
    .rise_i   (sclk_rise),
    .bit_i    (sdata_s),
    .fire_o   (fire),
    .word_o   (word_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o       <= '0;
      is_index_o   <= 1'b0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= fire;
      if (fire) begin
        word_o     <= word_next;
        is_index_o <= index_flag(rsel_s);
      end
    end
  end

  // R3: each pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R3: a pulse follows only a completed word
  a_r3_pulse_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(fire));

  // R4: the tag follows the select level seen with the final bit
  a_r4_tag_from_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (is_index_o == !$past(rsel_s)));

  // R6: no word is delivered outside serial mode
  a_r6_serial_only: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> ($past(mode_s) == MODE_SERIAL));

  // R7: no word is delivered unless both selects were asserted
  a_r7_both_selects: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> ($past(sel_p_s) && !$past(sel_n_s)));

  // R10: outputs hold between pulses
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> ($stable(word_o) && $stable(is_index_o)));

endmodule

// File: tb/serial_word_rx_tb_top.sv
module serial_word_rx_tb_top;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       sel_n = 1'b1;
  logic       sel_p = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       rsel = 1'b1;
  logic       disp_init_n = 1'b1;
  logic [7:0] word_o;
  logic       is_index_o;
  logic       word_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cap_word [0:63];
  logic       cap_idx  [0:63];
  int         cap_n = 0;

  always #10 clk = ~clk;

  serial_word_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sel_n(sel_n), .sel_p(sel_p),
    .sclk(sclk), .sdata(sdata), .rsel(rsel), .disp_init_n(disp_init_n),
    .word_o(word_o), .is_index_o(is_index_o), .word_valid_o(word_valid_o)
  );

  always @(negedge clk) begin
    if (word_valid_o && cap_n < 64) begin
      cap_word[cap_n] = word_o;
      cap_idx[cap_n]  = is_index_o;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send the top n bits of v; rsel is rs_last on bit 8 and rs_other before
  task automatic send_bits(input logic [7:0] v, input int n,
                           input logic rs_last, input logic rs_other);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata = v[7-i];
      rsel  = (i == 7) ? rs_last : rs_other;
      idle(HALF);
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
    idle(HALF);
  endtask

  task automatic select_on();
    mode_sel = 2'b00; sel_n = 1'b0; sel_p = 1'b1; idle(6);
  endtask

  task automatic test_reset();
    check("R1 word", word_o, 0);
    check("R1 index", is_index_o, 0);
    check("R1 valid", word_valid_o, 0);
  endtask

  task automatic test_basic();
    cap_n = 0;
    send_bits(8'hA5, 8, 1'b1, 1'b1);
    check("R3 one pulse", cap_n, 1);
    check("R2 msb first", cap_word[0], 8'hA5);
    check("R4 data tag", cap_idx[0], 0);
  endtask

  task automatic test_index();
    cap_n = 0;
    send_bits(8'h3C, 8, 1'b0, 1'b1);
    check("R3 one pulse", cap_n, 1);
    check("R2 word", cap_word[0], 8'h3C);
    check("R4 index tag", cap_idx[0], 1);
    cap_n = 0;
    send_bits(8'h96, 8, 1'b1, 1'b0);
    check("R4 late rsel high", cap_idx[0], 0);
  endtask

  task automatic test_burst();
    cap_n = 0;
    send_bits(8'h81, 8, 1'b0, 1'b0);
    send_bits(8'h7E, 8, 1'b1, 1'b1);
    send_bits(8'h01, 8, 1'b0, 1'b1);
    check("R5 burst count", cap_n, 3);
    check("R5 word0", cap_word[0], 8'h81);
    check("R5 word1", cap_word[1], 8'h7E);
    check("R5 word2", cap_word[2], 8'h01);
    check("R5 tags", {cap_idx[0], cap_idx[1], cap_idx[2]}, 3'b101);
  endtask

  task automatic test_mode();
    cap_n = 0;
    mode_sel = 2'b01; idle(6);
    send_bits(8'hF0, 8, 1'b1, 1'b1);
    mode_sel = 2'b10; idle(6);
    send_bits(8'h0F, 8, 1'b1, 1'b1);
    mode_sel = 2'b11; idle(6);
    send_bits(8'h55, 8, 1'b1, 1'b1);
    check("R6 no pulse outside serial", cap_n, 0);
    check("R10 word held", word_o, 8'h01);
    check("R10 tag held", is_index_o, 1);
    select_on();
  endtask

  task automatic test_select();
    cap_n = 0;
    sel_n = 1'b1; idle(6);
    send_bits(8'hAA, 8, 1'b1, 1'b1);
    sel_n = 1'b0; sel_p = 1'b0; idle(6);
    send_bits(8'hBB, 8, 1'b1, 1'b1);
    check("R7 no pulse when deselected", cap_n, 0);
    check("R7 word held", word_o, 8'h01);
    select_on();
  endtask

  task automatic test_deselect_mid();
    cap_n = 0;
    send_bits(8'hFF, 3, 1'b1, 1'b1);
    sel_p = 1'b0; idle(8);
    select_on();
    send_bits(8'h5A, 8, 1'b1, 1'b1);
    check("R8 single word", cap_n, 1);
    check("R8 realigned", cap_word[0], 8'h5A);
  endtask

  task automatic test_init();
    cap_n = 0;
    send_bits(8'hE0, 4, 1'b1, 1'b1);
    disp_init_n = 1'b0; idle(8);
    disp_init_n = 1'b1; idle(6);
    send_bits(8'hC3, 8, 1'b0, 1'b1);
    check("R9 single word", cap_n, 1);
    check("R9 realigned", cap_word[0], 8'hC3);
    check("R9 tag", cap_idx[0], 1);
    check("R10 holds after", word_o, 8'hC3);
  endtask

  initial begin
    idle(4);
    test_reset();
    rst_n = 1'b1;
    idle(4);
    test_reset();
    select_on();
    test_basic();
    test_index();
    test_burst();
    test_mode();
    test_select();
    test_deselect_mid();
    test_init();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule